// File: doc/BRIEF.md
# Word-Addressed Pin Bank Controller

This block controls thirty-two general-purpose pins from a simple word-addressed register bus. The bus has an address, a write strobe, write data and combinational read data. Each pin's direction is chosen by a 3-bit function code. Ten codes are packed into each 32-bit function word, so four words cover all the pins. Software never writes the output latch directly. It raises bits through a set word and lowers them through a clear word, so it can change some pins without a read-modify-write of the others.

The pins' input levels pass through a two-stage synchronizer and can be read from a level word. A pad-configuration word drives a 24-bit setting out to the pad ring. It is guarded by a key: a write takes effect only when the top byte of the written data carries the key value 0x5A. Bus writes take effect at the rising clock edge. Reads return the addressed word in the same cycle.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, every function code is 0 (input), the output latch and pin_out are all zero, pin_oe is all zero and pad_cfg is zero.
- R2: Function word w (bus index 0 to 3) holds pin p, where w = p/10, in bits [3*(p%10)+2 : 3*(p%10)]. A read of word w returns the codes stored by earlier writes. Bits that belong to no pin read as 0: bits 31:30 of every word, and bits 31:6 of word 3.
- R3: pin_oe[p] is 1 exactly when pin p's code is 1. Code 0 and codes 2 to 7 are stored and read back unchanged, but they leave pin_oe[p] at 0.
- R4: A write to index 7 sets each output latch bit whose write-data bit is 1 and leaves the others unchanged. A read of index 7 returns 0.
- R5: A write to index 10 clears each output latch bit whose write-data bit is 1 and leaves the others unchanged. A read of index 10 returns 0.
- R6: A read of index 13 returns pin_in delayed by two rising edges. A change of pin_in is not yet visible after one edge and is visible after the second.
- R7: A write to index 14 loads bits 23:0 into pad_cfg only when bits 31:24 equal 0x5A. Any other top byte leaves pad_cfg unchanged. A read of index 14 returns {8'h00, pad_cfg}.
- R8: Writes to the unmapped indices (4, 5, 6, 8, 9, 11, 12, 15) change neither pin_out, nor pin_oe, nor pad_cfg. Reads of those indices return 0.
- R9: pin_out and pin_oe change only at the rising edge that samples a write. Before that edge they still show the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pin input levels, asynchronous |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Per-pin output enable |
| pad_cfg | output | 24 | Pad configuration setting |

## Verification
All of the state in this block is visible at its ports. A function code filed under the wrong pin or bit offset shows on pin_oe one edge after the write, and it shows on the readback of the word at once. A set or clear that disturbs bits written as 0 corrupts pin_out at the next edge. The bench tracks pin_out after every set and clear, so such a fault shows at once. A synchronizer with the wrong depth shifts the level readback by one cycle, and the bench samples that readback after exactly one edge and after exactly two. A key guard that is too weak or too strict shows on pad_cfg right after the keyed write or the unkeyed one.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int FSEL_W        = 3;
  localparam int WORD_W        = 32;
  localparam int PINS_PER_WORD = WORD_W / FSEL_W;
  localparam logic [FSEL_W-1:0] FSEL_INPUT  = 3'd0;
  localparam logic [FSEL_W-1:0] FSEL_OUTPUT = 3'd1;
  localparam logic [7:0] PAD_KEY = 8'h5A;

  // Which function word holds pin p.
  function automatic int fsel_word(input int p);
    return p / PINS_PER_WORD;
  endfunction

  // Lowest bit of pin p's field inside its word.
  function automatic int fsel_lsb(input int p);
    return (p % PINS_PER_WORD) * FSEL_W;
  endfunction

  // Output enable for a function code: only the output code drives.
  function automatic logic fsel_drives(input logic [FSEL_W-1:0] code);
    return code == FSEL_OUTPUT;
  endfunction
endpackage

// File: rtl/pinbank_fsel.sv
module pinbank_fsel
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int NWORDS   = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
  parameter int WIDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WIDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [WIDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_PINS-1:0] oe
);
  localparam int USED_W = FSEL_W * PINS_PER_WORD;

  logic [NUM_PINS-1:0][FSEL_W-1:0] fsel_q;
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:USED_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (fsel_word(p) == int'(wr_idx))
          fsel_q[p] <= wr_data[fsel_lsb(p) +: FSEL_W];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (fsel_word(p) == int'(rd_idx))
        rd_data[fsel_lsb(p) +: FSEL_W] = fsel_q[p];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign oe[p] = fsel_drives(fsel_q[p]);
  end
endmodule

// File: rtl/pinbank_outlatch.sv
module pinbank_outlatch #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_stb,
  input  logic                clr_stb,
  input  logic [NUM_PINS-1:0] mask,
  output logic [NUM_PINS-1:0] q
);
  logic [NUM_PINS-1:0] set_m, clr_m;
  assign set_m = set_stb ? mask : '0;
  assign clr_m = clr_stb ? mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinbank_padguard.sv
module pinbank_padguard
  import pinbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAD_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_ok,
  output logic [PAD_W-1:0]  pad_q
);
  assign key_ok = wr_data[DATA_W-1 -: 8] == PAD_KEY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pad_q <= '0;
    else if (wr_stb && key_ok) pad_q <= wr_data[PAD_W-1:0];
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int PAD_W    = 24,
  parameter int SET_IDX  = 7,
  parameter int CLR_IDX  = 10,
  parameter int LVL_IDX  = 13,
  parameter int PAD_IDX  = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [PAD_W-1:0]    pad_cfg
);
  localparam int NWORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  // Decoded bus events, named for the checker.
  logic fsel_hit, set_hit, clr_hit, pad_hit, pad_key_ok;
  assign fsel_hit = int'(bus_addr) < NWORDS;
  assign set_hit  = bus_we && int'(bus_addr) == SET_IDX;
  assign clr_hit  = bus_we && int'(bus_addr) == CLR_IDX;
  assign pad_hit  = bus_we && int'(bus_addr) == PAD_IDX;

  logic [WIDX_W-1:0]   widx;
  logic [DATA_W-1:0]   fsel_rd;
  logic [NUM_PINS-1:0] level;
  assign widx = bus_addr[WIDX_W-1:0];

  pinbank_fsel #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .NWORDS(NWORDS), .WIDX_W(WIDX_W)) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we && fsel_hit), .wr_idx(widx),
    .wr_data(bus_wdata), .rd_idx(widx), .rd_data(fsel_rd), .oe(pin_oe)
  );

  pinbank_outlatch #(.NUM_PINS(NUM_PINS)) u_out (
    .clk(clk), .rst_n(rst_n), .set_stb(set_hit), .clr_stb(clr_hit),
    .mask(bus_wdata[NUM_PINS-1:0]), .q(pin_out)
  );

  pinbank_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level)
  );

  pinbank_padguard #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_pad (
    .clk(clk), .rst_n(rst_n), .wr_stb(pad_hit), .wr_data(bus_wdata),
    .key_ok(pad_key_ok), .pad_q(pad_cfg)
  );

  always_comb begin
    bus_rdata = '0;
    if (fsel_hit)                          bus_rdata = fsel_rd;
    else if (int'(bus_addr) == LVL_IDX)    bus_rdata[NUM_PINS-1:0] = level;
    else if (int'(bus_addr) == PAD_IDX)    bus_rdata[PAD_W-1:0] = pad_cfg;
  end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int PAD_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [31:0]       pin_out,
  input logic [31:0]       pin_oe,
  input logic [PAD_W-1:0]  pad_cfg,
  input logic              set_hit,
  input logic              clr_hit,
  input logic              pad_hit,
  input logic              pad_key_ok
);
  // R4: written ones end up set, written zeros keep their old value
  p_set_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
                ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  // R5: written ones end up clear, written zeros keep their old value
  p_clr_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((pin_out & $past(bus_wdata)) == 32'd0) &&
                ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  // R4/R5: the set and clear words read back as zero
  p_setclr_rd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'd7 || bus_addr == 4'd10) |-> bus_rdata == '0);

  // R7: a write without the key leaves the pad setting alone
  p_pad_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_hit && !pad_key_ok) |=> $stable(pad_cfg));

  // R9: without a set or clear write, pin_out holds
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(pin_out));

  // R3: pin 0 drives exactly when its written code is 1
  p_oe_pin0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd0) |=> pin_oe[0] == ($past(bus_wdata[2:0]) == 3'd1));
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAD_W(PAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .pad_cfg(pad_cfg),
  .set_hit(set_hit), .clr_hit(clr_hit), .pad_hit(pad_hit), .pad_key_ok(pad_key_ok)
);

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [23:0] pad_cfg;

  always #2 clk = ~clk;  // 250 MHz

  pinbank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pad_cfg(pad_cfg)
  );

  typedef struct {
    int          sel;  // 0 rdata, 1 pin_out, 2 pin_oe, 3 pad_cfg
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model kept in the bench.
  logic [2:0]  m_code [32];
  logic [31:0] m_out = '0;
  logic [23:0] m_pad = '0;

  function automatic logic [31:0] m_word(input int w);
    logic [31:0] r = '0;
    int base = w * 10;
    for (int k = 0; k < 10; k++)
      if (base + k < 32) r[k*3 +: 3] = m_code[base + k];
    return r;
  endfunction

  function automatic logic [31:0] m_oe();
    logic [31:0] r = '0;
    for (int p = 0; p < 32; p++) r[p] = (m_code[p] == 3'd1);
    return r;
  endfunction

  // Monitor: pops expectations and compares them with the ports.
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      case (it.sel)
        0: act = bus_rdata;
        1: act = pin_out;
        2: act = pin_oe;
        default: act = {8'h00, pad_cfg};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_sig(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    expect_sig(0, exp, tag);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a < 4) begin
      for (int p = 0; p < 32; p++) if (p / 10 == a) m_code[p] = d[(p % 10) * 3 +: 3];
    end
    if (a == 4'd7)  m_out = m_out | d;
    if (a == 4'd10) m_out = m_out & ~d;
    if (a == 4'd14 && d[31:24] == 8'h5A) m_pad = d[23:0];
  endtask

  task automatic check_all(input string tag);
    expect_sig(1, m_out, {tag, " pin_out"});
    expect_sig(2, m_oe(), {tag, " pin_oe"});
    expect_sig(3, {8'h00, m_pad}, {tag, " pad_cfg"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 32; p++) m_code[p] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1 reset");
    expect_rd(4'd0, 32'd0, "R1 fsel word0 after reset");

    // R2 / R3 packing and output enable, code 2 does not drive
    bus_wr(4'd0, (32'd1 << 0) | (32'd1 << 3) | (32'd2 << 6) | (32'd1 << 27));
    expect_rd(4'd0, m_word(0), "R2 word0 readback");
    expect_sig(2, 32'h0000_0203, "R3 oe pins 0,1,9");

    // R2 word3 only backs pins 30,31; R3 code 7 does not drive
    bus_wr(4'd3, 32'hFFFF_FFFF);
    expect_rd(4'd3, 32'h0000_003F, "R2 word3 partial readback");
    expect_sig(2, m_oe(), "R3 code 7 stays input");
    bus_wr(4'd3, 32'h0000_0009);
    expect_sig(2, 32'hC000_0203, "R3 pins 30,31 output");
    bus_wr(4'd1, 32'h4000_0001);
    expect_rd(4'd1, 32'h0000_0001, "R2 word1 top bits read zero");
    expect_rd(4'd0, m_word(0), "R2 word0 untouched by word1 write");
    expect_sig(2, m_oe(), "R3 pin 10 output");

    // R4 set semantics
    bus_wr(4'd7, 32'h8000_0401);
    expect_sig(1, 32'h8000_0401, "R4 set first");
    bus_wr(4'd7, 32'h0000_0002);
    expect_sig(1, 32'h8000_0403, "R4 zeros ignored");
    expect_rd(4'd7, 32'd0, "R4 set word reads zero");

    // R5 clear semantics
    bus_wr(4'd10, 32'h0000_0001);
    expect_sig(1, 32'h8000_0402, "R5 clear bit0");
    bus_wr(4'd10, 32'h0000_0000);
    expect_sig(1, m_out, "R5 zero clear ignored");
    expect_rd(4'd10, 32'd0, "R5 clear word reads zero");

    // R6 level synchronizer latency
    @(negedge clk);
    pin_in = 32'hA5A5_0F0F;
    bus_addr = 4'd13;
    @(negedge clk);
    expect_rd(4'd13, 32'd0, "R6 not visible after one edge");
    @(negedge clk);
    expect_rd(4'd13, 32'hA5A5_0F0F, "R6 visible after two edges");
    pin_in = 32'h0000_FFFF;
    repeat (2) @(negedge clk);
    expect_rd(4'd13, 32'h0000_FFFF, "R6 second pattern");

    // R7 pad key guard
    bus_wr(4'd14, 32'h5A00_0009);
    expect_sig(3, 32'h0000_0009, "R7 keyed write");
    bus_wr(4'd14, 32'h1200_0003);
    expect_sig(3, 32'h0000_0009, "R7 no key ignored");
    bus_wr(4'd14, 32'h5B12_3456);
    expect_sig(3, 32'h0000_0009, "R7 near key ignored");
    expect_rd(4'd14, 32'h0000_0009, "R7 pad readback");

    // R8 unmapped indices
    bus_wr(4'd5, 32'hFFFF_FFFF);
    bus_wr(4'd15, 32'h5AFF_FFFF);
    bus_wr(4'd11, 32'hFFFF_FFFF);
    check_all("R8 unmapped writes");
    expect_rd(4'd5, 32'd0, "R8 unmapped read");
    expect_rd(4'd12, 32'd0, "R8 unmapped read 12");

    // R9 outputs change only at the sampling edge
    @(negedge clk);
    bus_addr = 4'd7; bus_we = 1'b1; bus_wdata = 32'h0000_00F0;
    #1;
    expect_sig(1, m_out, "R9 pin_out before edge");
    @(negedge clk);
    bus_we = 1'b0;
    m_out = m_out | 32'h0000_00F0;
    expect_sig(1, m_out, "R9 pin_out after edge");
    @(negedge clk);
    bus_addr = 4'd0; bus_we = 1'b1; bus_wdata = 32'd0;
    #1;
    expect_sig(2, m_oe(), "R9 pin_oe before edge");
    @(negedge clk);
    bus_we = 1'b0;
    for (int p = 0; p < 10; p++) m_code[p] = 3'd0;
    expect_sig(2, m_oe(), "R9 pin_oe after edge");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule